// File: doc/BRIEF.md
# Coprocessor Branch and Next-PC Unit

This block holds the program counter of a small word-addressed coprocessor and works out, every cycle, which instruction word comes next. The decoder presents the fields of the current instruction: what kind of branch it is, a condition code, the relative offset as a magnitude with a direction bit, a 16-bit compare immediate, an absolute target and a bit that selects a register target instead. The unit also receives the R0 value, the stage counter, the ALU zero and overflow flags and a register value for register targets.

Each addressing mode has its own condition family. Relative branches test either R0 or the stage counter against the immediate. Absolute branches test the ALU flags. The taken indication and the next PC are combinational from the present inputs, and the PC register loads the next PC on every rising clock edge. Every address calculation wraps modulo the PC range.

Top module: `cpbr_next_pc`

## Requirements
- R1: While `rst` is high at a rising edge, `pc` becomes 0.
- R2: When `br_kind` is 0 (no branch), or the selected condition fails, `taken` is 0 and `next_pc` equals `pc`+1 modulo 2048, so 2047 steps to 0.
- R3: When `br_kind` is 1 (relative on R0), the branch is taken when the unsigned `r0_val` compared with `cmp_imm` satisfies the test chosen by `br_cond`: 0 for less-than, 1 for greater-than, 2 for equal.
- R4: When `br_kind` is 2 (relative on the stage counter), the branch is taken when the unsigned `stage_val` compared with `cmp_imm[7:0]` satisfies the test chosen by `br_cond`: 0 for less-than, 1 for greater-or-equal, 2 for less-or-equal.
- R5: When `br_kind` is 3 (absolute), `br_cond` 0 is always taken, 1 is taken when `alu_zero` is 1, and 2 is taken when `alu_ovf` is 1.
- R6: When a relative branch is taken, `next_pc` is `pc`+`off_mag` if `off_neg` is 0 and `pc`-`off_mag` if `off_neg` is 1, modulo 2048. A magnitude of 0 gives `pc` itself.
- R7: When an absolute branch is taken, `next_pc` is `tgt_imm` if `tgt_sel_reg` is 0 and `tgt_reg_val[10:0]` if it is 1. The upper bits of the register value are ignored.
- R8: A `br_cond` value of 3 is never taken, whatever the branch kind.
- R9: At each rising edge with `rst` low, `pc` takes the value `next_pc` had before that edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| br_kind | input | 2 | 0 none, 1 relative on R0, 2 relative on stage counter, 3 absolute |
| br_cond | input | 2 | Condition code within the family of the branch kind |
| off_neg | input | 1 | Relative direction: 0 forward, 1 backward |
| off_mag | input | 7 | Relative offset magnitude in words |
| cmp_imm | input | 16 | Compare immediate |
| tgt_sel_reg | input | 1 | Absolute target source: 0 immediate, 1 register |
| tgt_imm | input | 11 | Absolute immediate target in words |
| r0_val | input | 16 | Current R0 value |
| stage_val | input | 8 | Current stage counter |
| alu_zero | input | 1 | Last ALU result was zero |
| alu_ovf | input | 1 | Last ALU operation overflowed |
| tgt_reg_val | input | 16 | Register value for register targets |
| pc | output | 11 | Program counter register |
| next_pc | output | 11 | Combinational next program counter |
| taken | output | 1 | Combinational branch-taken indication |

## Verification
A wrong condition decode shows up on `taken` and `next_pc` in the same cycle it is presented. The tests therefore sit on the equality boundaries of each compare, where off-by-one mistakes would flip the result. A wrong offset or target calculation shows on `next_pc` at once and in `pc` one edge later. Forward and backward wraps across the ends of the address range are checked in particular. A PC register that misses an update or loads the wrong source is visible on `pc` right after the edge, because every step checks the new value against the expected one.

// File: rtl/cpbr_pkg.sv
package cpbr_pkg;

    typedef enum logic [1:0] {
        KIND_NONE  = 2'd0,
        KIND_R0    = 2'd1,
        KIND_STAGE = 2'd2,
        KIND_ABS   = 2'd3
    } br_kind_e;

    typedef enum logic [1:0] {
        R0_LT = 2'd0,
        R0_GT = 2'd1,
        R0_EQ = 2'd2,
        R0_RSV = 2'd3
    } r0_cond_e;

    typedef enum logic [1:0] {
        ST_LT = 2'd0,
        ST_GE = 2'd1,
        ST_LE = 2'd2,
        ST_RSV = 2'd3
    } stage_cond_e;

    typedef enum logic [1:0] {
        AB_DIRECT = 2'd0,
        AB_ZERO   = 2'd1,
        AB_OVF    = 2'd2,
        AB_RSV    = 2'd3
    } abs_cond_e;

    typedef struct packed {
        logic alu_zero;
        logic alu_ovf;
    } alu_flags_t;

endpackage

// File: rtl/cpbr_cond_eval.sv
module cpbr_cond_eval
    import cpbr_pkg::*;
#(
    parameter int DATA_W  = 16,
    parameter int STAGE_W = 8
) (
    input  br_kind_e            kind,
    input  logic [1:0]          cond,
    input  logic [DATA_W-1:0]   r0_val,
    input  logic [DATA_W-1:0]   cmp_imm,
    input  logic [STAGE_W-1:0]  stage_val,
    input  alu_flags_t          flags,
    output logic                hit
);

    logic [STAGE_W-1:0] stage_imm;
    logic               r0_hit;
    logic               stage_hit;
    logic               abs_hit;

    assign stage_imm = cmp_imm[STAGE_W-1:0];

    always_comb begin
        case (r0_cond_e'(cond))
            R0_LT:   r0_hit = (r0_val < cmp_imm);
            R0_GT:   r0_hit = (r0_val > cmp_imm);
            R0_EQ:   r0_hit = (r0_val == cmp_imm);
            default: r0_hit = 1'b0;
        endcase
    end

    always_comb begin
        case (stage_cond_e'(cond))
            ST_LT:   stage_hit = (stage_val < stage_imm);
            ST_GE:   stage_hit = (stage_val >= stage_imm);
            ST_LE:   stage_hit = (stage_val <= stage_imm);
            default: stage_hit = 1'b0;
        endcase
    end

    always_comb begin
        case (abs_cond_e'(cond))
            AB_DIRECT: abs_hit = 1'b1;
            AB_ZERO:   abs_hit = flags.alu_zero;
            AB_OVF:    abs_hit = flags.alu_ovf;
            default:   abs_hit = 1'b0;
        endcase
    end

    always_comb begin
        case (kind)
            KIND_R0:    hit = r0_hit;
            KIND_STAGE: hit = stage_hit;
            KIND_ABS:   hit = abs_hit;
            default:    hit = 1'b0;
        endcase
    end

endmodule

// File: rtl/cpbr_target_gen.sv
module cpbr_target_gen #(
    parameter int PC_W   = 11,
    parameter int OFF_W  = 7,
    parameter int DATA_W = 16
) (
    input  logic [PC_W-1:0]   pc,
    input  logic              off_neg,
    input  logic [OFF_W-1:0]  off_mag,
    input  logic              sel_reg,
    input  logic [PC_W-1:0]   tgt_imm,
    input  logic [DATA_W-1:0] reg_val,
    output logic [PC_W-1:0]   seq_pc,
    output logic [PC_W-1:0]   rel_pc,
    output logic [PC_W-1:0]   abs_pc
);

    localparam int PAD_W = PC_W - OFF_W;

    logic [PC_W-1:0] off_ext;

    generate
        if (PAD_W > 0) begin : g_pad
            assign off_ext = {{PAD_W{1'b0}}, off_mag};
        end else begin : g_trunc
            assign off_ext = off_mag[PC_W-1:0];
        end
        if (DATA_W > PC_W) begin : g_hi
            logic unused_hi;
            assign unused_hi = ^reg_val[DATA_W-1:PC_W];
        end
    endgenerate

    assign seq_pc = pc + {{(PC_W-1){1'b0}}, 1'b1};
    assign rel_pc = off_neg ? (pc - off_ext) : (pc + off_ext);
    assign abs_pc = sel_reg ? reg_val[PC_W-1:0] : tgt_imm;

endmodule

// File: rtl/cpbr_next_pc.sv
module cpbr_next_pc
    import cpbr_pkg::*;
#(
    parameter int PC_W    = 11,
    parameter int OFF_W   = 7,
    parameter int DATA_W  = 16,
    parameter int STAGE_W = 8
) (
    input  logic                clk,
    input  logic                rst,
    input  logic [1:0]          br_kind,
    input  logic [1:0]          br_cond,
    input  logic                off_neg,
    input  logic [OFF_W-1:0]    off_mag,
    input  logic [DATA_W-1:0]   cmp_imm,
    input  logic                tgt_sel_reg,
    input  logic [PC_W-1:0]     tgt_imm,
    input  logic [DATA_W-1:0]   r0_val,
    input  logic [STAGE_W-1:0]  stage_val,
    input  logic                alu_zero,
    input  logic                alu_ovf,
    input  logic [DATA_W-1:0]   tgt_reg_val,
    output logic [PC_W-1:0]     pc,
    output logic [PC_W-1:0]     next_pc,
    output logic                taken
);

    br_kind_e        kind;
    alu_flags_t      flags;
    logic            hit;
    logic [PC_W-1:0] seq_pc;
    logic [PC_W-1:0] rel_pc;
    logic [PC_W-1:0] abs_pc;

    assign kind  = br_kind_e'(br_kind);
    assign flags = '{alu_zero: alu_zero, alu_ovf: alu_ovf};

    cpbr_cond_eval #(
        .DATA_W  (DATA_W),
        .STAGE_W (STAGE_W)
    ) u_cond (
        .kind      (kind),
        .cond      (br_cond),
        .r0_val    (r0_val),
        .cmp_imm   (cmp_imm),
        .stage_val (stage_val),
        .flags     (flags),
        .hit       (hit)
    );

    cpbr_target_gen #(
        .PC_W   (PC_W),
        .OFF_W  (OFF_W),
        .DATA_W (DATA_W)
    ) u_tgt (
        .pc      (pc),
        .off_neg (off_neg),
        .off_mag (off_mag),
        .sel_reg (tgt_sel_reg),
        .tgt_imm (tgt_imm),
        .reg_val (tgt_reg_val),
        .seq_pc  (seq_pc),
        .rel_pc  (rel_pc),
        .abs_pc  (abs_pc)
    );

    always_comb begin
        if (!hit) begin
            next_pc = seq_pc;
        end else if (kind == KIND_ABS) begin
            next_pc = abs_pc;
        end else begin
            next_pc = rel_pc;
        end
    end

    assign taken = hit;

    always_ff @(posedge clk) begin
        if (rst) begin
            pc <= '0;
        end else begin
            pc <= next_pc;
        end
    end

endmodule

// File: rtl/cpbr_next_pc_chk.sv
module cpbr_next_pc_chk #(
    parameter int PC_W  = 11,
    parameter int OFF_W = 7
) (
    input logic            clk,
    input logic            rst,
    input logic [1:0]      br_kind,
    input logic [1:0]      br_cond,
    input logic            off_neg,
    input logic [OFF_W-1:0] off_mag,
    input logic [PC_W-1:0] pc,
    input logic [PC_W-1:0] next_pc,
    input logic            taken
);

    // R1
    reset_zero_chk: assert property (@(posedge clk) rst |=> pc == '0);

    // R9
    pc_follow_chk: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> pc == $past(next_pc));

    // R2
    no_branch_chk: assert property (@(posedge clk) disable iff (rst)
        br_kind == 2'd0 |-> !taken);

    // R2
    seq_step_chk: assert property (@(posedge clk) disable iff (rst)
        !taken |-> next_pc == PC_W'(pc + 1'b1));

    // R8
    rsv_cond_chk: assert property (@(posedge clk) disable iff (rst)
        br_cond == 2'd3 |-> !taken);

    // R5
    direct_abs_chk: assert property (@(posedge clk) disable iff (rst)
        (br_kind == 2'd3 && br_cond == 2'd0) |-> taken);

    // R6
    rel_fwd_chk: assert property (@(posedge clk) disable iff (rst)
        (taken && (br_kind == 2'd1 || br_kind == 2'd2) && !off_neg)
            |-> next_pc == PC_W'(pc + PC_W'(off_mag)));

    // R6
    rel_back_chk: assert property (@(posedge clk) disable iff (rst)
        (taken && (br_kind == 2'd1 || br_kind == 2'd2) && off_neg)
            |-> next_pc == PC_W'(pc - PC_W'(off_mag)));

endmodule

bind cpbr_next_pc cpbr_next_pc_chk #(
    .PC_W  (PC_W),
    .OFF_W (OFF_W)
) u_chk (
    .clk     (clk),
    .rst     (rst),
    .br_kind (br_kind),
    .br_cond (br_cond),
    .off_neg (off_neg),
    .off_mag (off_mag),
    .pc      (pc),
    .next_pc (next_pc),
    .taken   (taken)
);

// File: tb/sim_cpbr_next_pc.sv
module sim_cpbr_next_pc;

    localparam int CLK_P = 10;

    logic        clk = 1'b0;
    logic        rst;
    logic [1:0]  br_kind;
    logic [1:0]  br_cond;
    logic        off_neg;
    logic [6:0]  off_mag;
    logic [15:0] cmp_imm;
    logic        tgt_sel_reg;
    logic [10:0] tgt_imm;
    logic [15:0] r0_val;
    logic [7:0]  stage_val;
    logic        alu_zero;
    logic        alu_ovf;
    logic [15:0] tgt_reg_val;
    logic [10:0] pc;
    logic [10:0] next_pc;
    logic        taken;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    always #(CLK_P/2) clk = ~clk;

    cpbr_next_pc u0 (
        .clk         (clk),
        .rst         (rst),
        .br_kind     (br_kind),
        .br_cond     (br_cond),
        .off_neg     (off_neg),
        .off_mag     (off_mag),
        .cmp_imm     (cmp_imm),
        .tgt_sel_reg (tgt_sel_reg),
        .tgt_imm     (tgt_imm),
        .r0_val      (r0_val),
        .stage_val   (stage_val),
        .alu_zero    (alu_zero),
        .alu_ovf     (alu_ovf),
        .tgt_reg_val (tgt_reg_val),
        .pc          (pc),
        .next_pc     (next_pc),
        .taken       (taken)
    );

    task automatic chk(string tag, int act, int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic clear_in();
        br_kind = 2'd0; br_cond = 2'd0; off_neg = 1'b0; off_mag = 7'd0;
        cmp_imm = 16'd0; tgt_sel_reg = 1'b0; tgt_imm = 11'd0;
        r0_val = 16'd0; stage_val = 8'd0; alu_zero = 1'b0; alu_ovf = 1'b0;
        tgt_reg_val = 16'd0;
    endtask

    // present current inputs, check outputs, clock, check pc
    task automatic step(string tag, int exp_next, bit exp_tk);
        #1;
        chk({tag, " taken"}, int'(taken), int'(exp_tk));
        chk({tag, " next_pc"}, int'(next_pc), exp_next);
        @(posedge clk);
        #1;
        chk({tag, " R9 pc"}, int'(pc), exp_next);
        @(negedge clk);
        clear_in();
    endtask

    task automatic set_pc(int a);
        br_kind = 2'd3; br_cond = 2'd0; tgt_imm = 11'(a);
        step("R7 set_pc", a, 1'b1);
    endtask

    task automatic t_reset();
        chk("R1 reset pc", int'(pc), 0);
    endtask

    task automatic t_seq();
        step("R2 none from 0", 1, 1'b0);
        set_pc(2047);
        r0_val = 16'd1; cmp_imm = 16'd9; off_mag = 7'd5;
        step("R2 wrap", 0, 1'b0);
    endtask

    task automatic t_r0();
        set_pc(100); br_kind = 2'd1; br_cond = 2'd0; r0_val = 16'd5; cmp_imm = 16'd6; off_mag = 7'd10;
        step("R3 lt hit", 110, 1'b1);
        set_pc(100); br_kind = 2'd1; br_cond = 2'd0; r0_val = 16'd6; cmp_imm = 16'd6; off_mag = 7'd10;
        step("R3 lt equal", 101, 1'b0);
        set_pc(100); br_kind = 2'd1; br_cond = 2'd1; r0_val = 16'h8000; cmp_imm = 16'd1; off_mag = 7'd10;
        step("R3 gt unsigned", 110, 1'b1);
        set_pc(100); br_kind = 2'd1; br_cond = 2'd1; r0_val = 16'd1; cmp_imm = 16'd1; off_mag = 7'd10;
        step("R3 gt equal", 101, 1'b0);
        set_pc(100); br_kind = 2'd1; br_cond = 2'd2; r0_val = 16'h1234; cmp_imm = 16'h1234; off_mag = 7'd10;
        step("R3 eq hit", 110, 1'b1);
        set_pc(100); br_kind = 2'd1; br_cond = 2'd2; r0_val = 16'h1235; cmp_imm = 16'h1234; off_mag = 7'd10;
        step("R3 eq miss", 101, 1'b0);
    endtask

    task automatic t_stage();
        set_pc(200); br_kind = 2'd2; br_cond = 2'd0; stage_val = 8'd7; cmp_imm = 16'd7; off_mag = 7'd3;
        step("R4 lt equal", 201, 1'b0);
        set_pc(200); br_kind = 2'd2; br_cond = 2'd0; stage_val = 8'd6; cmp_imm = 16'd7; off_mag = 7'd3;
        step("R4 lt hit", 203, 1'b1);
        set_pc(200); br_kind = 2'd2; br_cond = 2'd1; stage_val = 8'd7; cmp_imm = 16'd7; off_mag = 7'd3;
        step("R4 ge equal", 203, 1'b1);
        set_pc(200); br_kind = 2'd2; br_cond = 2'd1; stage_val = 8'd6; cmp_imm = 16'd7; off_mag = 7'd3;
        step("R4 ge miss", 201, 1'b0);
        set_pc(200); br_kind = 2'd2; br_cond = 2'd2; stage_val = 8'd7; cmp_imm = 16'd7; off_mag = 7'd3;
        step("R4 le equal", 203, 1'b1);
        set_pc(200); br_kind = 2'd2; br_cond = 2'd2; stage_val = 8'd8; cmp_imm = 16'd7; off_mag = 7'd3;
        step("R4 le miss", 201, 1'b0);
        set_pc(200); br_kind = 2'd2; br_cond = 2'd1; stage_val = 8'hFF; cmp_imm = 16'hFF00; off_mag = 7'd3;
        step("R4 ge low byte", 203, 1'b1);
    endtask

    task automatic t_abs();
        set_pc(100); br_kind = 2'd3; br_cond = 2'd1; alu_zero = 1'b1; tgt_imm = 11'd500;
        step("R5 zero hit", 500, 1'b1);
        set_pc(100); br_kind = 2'd3; br_cond = 2'd1; alu_ovf = 1'b1; tgt_imm = 11'd500;
        step("R5 zero miss", 101, 1'b0);
        set_pc(100); br_kind = 2'd3; br_cond = 2'd2; alu_ovf = 1'b1; tgt_imm = 11'd500;
        step("R5 ovf hit", 500, 1'b1);
        set_pc(100); br_kind = 2'd3; br_cond = 2'd2; alu_zero = 1'b1; tgt_imm = 11'd500;
        step("R5 ovf miss", 101, 1'b0);
    endtask

    task automatic t_rel_wrap();
        set_pc(2040); br_kind = 2'd1; br_cond = 2'd2; off_mag = 7'd127;
        step("R6 fwd wrap", 119, 1'b1);
        set_pc(3); br_kind = 2'd1; br_cond = 2'd2; off_neg = 1'b1; off_mag = 7'd127;
        step("R6 back wrap", 1924, 1'b1);
        set_pc(3); br_kind = 2'd2; br_cond = 2'd1; off_neg = 1'b1; off_mag = 7'd0;
        step("R6 zero offset", 3, 1'b1);
        set_pc(300); br_kind = 2'd2; br_cond = 2'd1; off_neg = 1'b1; off_mag = 7'd20;
        step("R6 back stage", 280, 1'b1);
    endtask

    task automatic t_abs_reg();
        set_pc(100); br_kind = 2'd3; br_cond = 2'd0; tgt_sel_reg = 1'b1;
        tgt_reg_val = 16'hF805; tgt_imm = 11'd700;
        step("R7 reg target", 5, 1'b1);
        set_pc(100); br_kind = 2'd3; br_cond = 2'd0; tgt_sel_reg = 1'b0;
        tgt_reg_val = 16'd33; tgt_imm = 11'd700;
        step("R7 imm target", 700, 1'b1);
    endtask

    task automatic t_rsv();
        set_pc(100); br_kind = 2'd1; br_cond = 2'd3; r0_val = 16'd4; cmp_imm = 16'd4; off_mag = 7'd9;
        step("R8 r0 rsv", 101, 1'b0);
        set_pc(100); br_kind = 2'd2; br_cond = 2'd3; stage_val = 8'd4; cmp_imm = 16'd4; off_mag = 7'd9;
        step("R8 stage rsv", 101, 1'b0);
        set_pc(100); br_kind = 2'd3; br_cond = 2'd3; alu_zero = 1'b1; alu_ovf = 1'b1; tgt_imm = 11'd9;
        step("R8 abs rsv", 101, 1'b0);
    endtask

    initial begin
        #(CLK_P * 100000);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        clear_in();
        rst = 1'b1;
        repeat (3) @(posedge clk);
        #1;
        t_reset();
        @(negedge clk);
        rst = 1'b0;
        t_seq();
        t_r0();
        t_stage();
        t_abs();
        t_rel_wrap();
        t_abs_reg();
        t_rsv();
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule